// File: doc/BRIEF.md
# Symbol Timing Recovery Loop

This block recovers the symbol clock from a matched-filtered complex baseband stream sampled at four samples per symbol. Each accepted input sample enters a four-tap piecewise-parabolic interpolator, built as a Farrow structure with alpha = 0.5, which evaluates the waveform at a fractional offset mu. A mod-1 counter steps down once per accepted sample. Its underflow marks the sample at which a symbol is taken (the strobe), and its residue sets mu.

On every strobe a Gardner detector compares the new interpolant with the previous one and with the interpolant half a symbol earlier. A proportional-plus-integral filter with power-of-two gains smooths that error and bends the counter step. The loop therefore moves the strobe towards the point of maximum eye opening. Only the strobed interpolant leaves the block, one cycle later, marked by a valid pulse.

Top module: `stl_timing_loop`

## Requirements
- R1: While rst_ni is low, and after reset until the first strobe, sym_valid_o is 0 and sym_re_o and sym_im_o are 0. Reset clears the delay line, the counter, mu, the filter state and the previous symbol.
- R2: The counter starts at 0, so the first accepted sample after reset strobes. With zero timing error, a strobe follows on every fourth accepted sample after that.
- R3: sym_valid_o is 1 exactly in the cycle after an accepted sample that strobes. sym_re_o and sym_im_o hold their value whenever sym_valid_o is 0.
- R4: With mu = 0 the emitted symbol equals the input from two accepted samples before the strobing sample. Samples before reset count as 0.
- R5: With x0 the current sample and x1..x3 the three previous ones, the interpolant is y = ((v2*mu >>> F) + v1)*mu >>> F + x2. Here v2 = (x0-x1-x2+x3)>>>1, v1 = (3*x1-x0-x2-x3)>>>1, F = CW, `>>>` rounds towards minus infinity, and the result saturates to DW bits. A constant input therefore passes unchanged for any mu.
- R6: The timing error is e = (yr-pr)*mr + (yi-pi)*mi, evaluated only on strobes and taken as 0 otherwise. Here y is the new interpolant, p is the previous strobed interpolant, and m is the interpolant computed two accepted samples earlier.
- R7: A positive error raises the counter step, so the next strobe comes earlier. With the default gains, an error of 2^26 at a strobe makes the next strobe follow after 3 accepted samples instead of 4.
- R8: The proportional term (e>>>KP_SHIFT) and the integrator are each clamped to ±2^(CW-4) and never wrap. Even after an error near -4.1e9, the next strobe still follows 4 accepted samples later.
- R9: The counter value lies in [0, 2^CW), and each accepted sample decrements it by 2^(CW-2) plus the filter output. On underflow it adds 2^CW, and mu = 4 * (value before the decrement), saturated to 2^CW-1.
- R10: A cycle with valid_i low changes no state and emits no symbol.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Input sample qualifier |
| din_re_i | input | DW | In-phase input sample, signed |
| din_im_i | input | DW | Quadrature input sample, signed |
| sym_valid_o | output | 1 | Pulse marking a recovered symbol |
| sym_re_o | output | DW | In-phase recovered symbol, signed |
| sym_im_o | output | DW | Quadrature recovered symbol, signed |

## Verification
Three things can happen in the same cycle: a symbol is emitted, the Gardner error updates the loop filter, and the counter wraps and sets the mu that the interpolator uses on that sample. Patterns are chosen so that the interpolant half a symbol back is nonzero at a chosen strobe. The effect of that error then shows in the next interval, which shortens to three samples or stays at four under clamping. The symbol taken at the shifted strobe is compared with the parabolic formula evaluated at the predicted mu. A constant stream confirms that a nonzero mu leaves a flat input unchanged. A gapped stream confirms that idle cycles move neither the strobe nor the held output.

// File: rtl/stl_pkg.sv
`timescale 1ns/1ps
package stl_pkg;
  // log2 of samples per symbol
  localparam int unsigned SPS_LOG2 = 2;
endpackage

// File: rtl/stl_farrow.sv
`timescale 1ns/1ps
module stl_farrow #(
  parameter int DW = 16,
  parameter int MW = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic signed [DW-1:0] x_i,
  input  logic        [MW-1:0] mu_i,
  output logic signed [DW-1:0] y_o,
  output logic signed [DW-1:0] mid_o
);
  localparam int VW = DW + 3;
  localparam int PW = VW + MW + 1;
  localparam logic signed [VW-1:0] YMAX = VW'((1 << (DW-1)) - 1);
  localparam logic signed [VW-1:0] YMIN = -YMAX - VW'(1);

  logic signed [DW-1:0] d1_q, d2_q, d3_q, yh1_q, yh2_q;
  logic signed [VW-1:0] x0, x1, x2, x3, v2, v1, t, s, u, ys;
  logic signed [MW:0]   mus;
  logic signed [PW-1:0] p1, p2;

  always_comb begin
    x0  = VW'(x_i);
    x1  = VW'(d1_q);
    x2  = VW'(d2_q);
    x3  = VW'(d3_q);
    v2  = (x0 - x1 - x2 + x3) >>> 1;
    v1  = (x1 + x1 + x1 - x0 - x2 - x3) >>> 1;
    mus = {1'b0, mu_i};
    p1  = PW'(v2) * PW'(mus);
    t   = VW'(p1 >>> MW);
    s   = t + v1;
    p2  = PW'(s) * PW'(mus);
    u   = VW'(p2 >>> MW);
    ys  = u + x2;
    if (ys > YMAX)      y_o = DW'(YMAX);
    else if (ys < YMIN) y_o = DW'(YMIN);
    else                y_o = DW'(ys);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      d1_q  <= '0;
      d2_q  <= '0;
      d3_q  <= '0;
      yh1_q <= '0;
      yh2_q <= '0;
    end else if (en_i) begin
      d1_q  <= x_i;
      d2_q  <= d1_q;
      d3_q  <= d2_q;
      yh1_q <= y_o;
      yh2_q <= yh1_q;
    end
  end

  // interpolant from two accepted samples back: half a symbol
  assign mid_o = yh2_q;
endmodule

// File: rtl/stl_ted.sv
`timescale 1ns/1ps
module stl_ted #(
  parameter int DW = 16,
  parameter int EW = 2*DW + 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 strobe_i,
  input  logic signed [DW-1:0] y_re_i,
  input  logic signed [DW-1:0] y_im_i,
  input  logic signed [DW-1:0] mid_re_i,
  input  logic signed [DW-1:0] mid_im_i,
  output logic signed [EW-1:0] err_o
);
  logic signed [DW-1:0] yp_re_q, yp_im_q;
  logic signed [DW:0]   dre, dim;
  logic signed [EW-1:0] pre, pim, sum;

  always_comb begin
    dre = (DW+1)'(y_re_i) - (DW+1)'(yp_re_q);
    dim = (DW+1)'(y_im_i) - (DW+1)'(yp_im_q);
    pre = EW'(dre) * EW'(mid_re_i);
    pim = EW'(dim) * EW'(mid_im_i);
    sum = pre + pim;
    err_o = strobe_i ? sum : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      yp_re_q <= '0;
      yp_im_q <= '0;
    end else if (strobe_i) begin
      yp_re_q <= y_re_i;
      yp_im_q <= y_im_i;
    end
  end
endmodule

// File: rtl/stl_loop_filter.sv
`timescale 1ns/1ps
module stl_loop_filter #(
  parameter int EW       = 34,
  parameter int CW       = 16,
  parameter int KP_SHIFT = 16,
  parameter int KI_SHIFT = 22
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic signed [EW-1:0] err_i,
  output logic signed [CW-1:0] adj_o,
  output logic signed [CW-1:0] integ_o
);
  localparam int LIM = 1 << (CW-4);
  localparam logic signed [EW-1:0] LIM_E = EW'(LIM);
  localparam logic signed [CW:0]   LIM_I = (CW+1)'(LIM);

  function automatic logic signed [CW-1:0] clampf(input logic signed [EW-1:0] a);
    if (a > LIM_E)       return CW'(LIM);
    else if (a < -LIM_E) return -CW'(LIM);
    else                 return CW'(a);
  endfunction

  logic signed [CW-1:0] adj_q, integ_q, p_term, i_term, integ_d;
  logic signed [CW:0]   isum;

  always_comb begin
    p_term = clampf(err_i >>> KP_SHIFT);
    i_term = clampf(err_i >>> KI_SHIFT);
    isum   = (CW+1)'(integ_q) + (CW+1)'(i_term);
    if (isum > LIM_I)       integ_d = CW'(LIM);
    else if (isum < -LIM_I) integ_d = -CW'(LIM);
    else                    integ_d = CW'(isum);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      adj_q   <= '0;
      integ_q <= '0;
    end else if (en_i) begin
      integ_q <= integ_d;
      adj_q   <= p_term + integ_d;
    end
  end

  assign adj_o   = adj_q;
  assign integ_o = integ_q;
endmodule

// File: rtl/stl_interp_ctrl.sv
`timescale 1ns/1ps
module stl_interp_ctrl #(
  parameter int CW       = 16,
  parameter int SPS_LOG2 = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic signed [CW-1:0] adj_i,
  output logic                 strobe_o,
  output logic        [CW-1:0] mu_o,
  output logic signed [CW+1:0] eta_o
);
  localparam int SW  = CW + SPS_LOG2;
  localparam int NOM = 1 << (CW - SPS_LOG2);
  localparam logic signed [CW+1:0] ONE = {2'b01, {CW{1'b0}}};

  logic signed [CW+1:0] eta_q, step, diff, eta_d;
  logic        [CW-1:0] mu_q, mu_new;
  logic        [SW-1:0] sc;

  always_comb begin
    step     = (CW+2)'(NOM) + (CW+2)'(adj_i);
    diff     = eta_q - step;
    strobe_o = en_i && diff[CW+1];
    eta_d    = diff[CW+1] ? diff + ONE : diff;
    // residue scaled by the nominal step reciprocal
    sc       = SW'(eta_q[CW-1:0]) << SPS_LOG2;
    mu_new   = (sc[SW-1:CW] != '0) ? '1 : sc[CW-1:0];
    mu_o     = strobe_o ? mu_new : mu_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eta_q <= '0;
      mu_q  <= '0;
    end else if (en_i) begin
      eta_q <= eta_d;
      if (strobe_o) mu_q <= mu_new;
    end
  end

  assign eta_o = eta_q;
endmodule

// File: rtl/stl_timing_loop.sv
`timescale 1ns/1ps
module stl_timing_loop #(
  parameter int DW       = 16,
  parameter int CW       = 16,
  parameter int KP_SHIFT = 16,
  parameter int KI_SHIFT = 22
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic signed [DW-1:0] din_re_i,
  input  logic signed [DW-1:0] din_im_i,
  output logic                 sym_valid_o,
  output logic signed [DW-1:0] sym_re_o,
  output logic signed [DW-1:0] sym_im_o
);
  localparam int EW = 2*DW + 2;
  localparam int NCH = 2;

  logic signed [DW-1:0] din [NCH];
  logic signed [DW-1:0] y   [NCH];
  logic signed [DW-1:0] mid [NCH];
  logic                 strobe;
  logic        [CW-1:0] mu;
  logic signed [CW-1:0] adj, integ;
  logic signed [CW+1:0] eta;
  logic signed [EW-1:0] err;

  assign din[0] = din_re_i;
  assign din[1] = din_im_i;

  stl_interp_ctrl #(.CW(CW), .SPS_LOG2(stl_pkg::SPS_LOG2)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(valid_i), .adj_i(adj),
    .strobe_o(strobe), .mu_o(mu), .eta_o(eta)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    stl_farrow #(.DW(DW), .MW(CW)) u_farrow (
      .clk_i(clk_i), .rst_ni(rst_ni), .en_i(valid_i), .x_i(din[c]),
      .mu_i(mu), .y_o(y[c]), .mid_o(mid[c])
    );
  end

  stl_ted #(.DW(DW), .EW(EW)) u_ted (
    .clk_i(clk_i), .rst_ni(rst_ni), .strobe_i(strobe),
    .y_re_i(y[0]), .y_im_i(y[1]), .mid_re_i(mid[0]), .mid_im_i(mid[1]),
    .err_o(err)
  );

  stl_loop_filter #(.EW(EW), .CW(CW), .KP_SHIFT(KP_SHIFT), .KI_SHIFT(KI_SHIFT)) u_lf (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(valid_i), .err_i(err),
    .adj_o(adj), .integ_o(integ)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sym_valid_o <= 1'b0;
      sym_re_o    <= '0;
      sym_im_o    <= '0;
    end else begin
      sym_valid_o <= strobe;
      if (strobe) begin
        sym_re_o <= y[0];
        sym_im_o <= y[1];
      end
    end
  end
endmodule

// File: rtl/stl_checker.sv
`timescale 1ns/1ps
module stl_checker #(
  parameter int DW = 16,
  parameter int CW = 16
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 valid_i,
  input logic                 sym_valid_o,
  input logic signed [DW-1:0] sym_re_o,
  input logic signed [DW-1:0] sym_im_o,
  input logic                 strobe,
  input logic signed [CW-1:0] adj,
  input logic signed [CW-1:0] integ,
  input logic signed [CW+1:0] eta
);
  localparam logic signed [CW-1:0] LIM  = CW'(1 << (CW-4));
  localparam logic signed [CW+1:0] ONE  = {2'b01, {CW{1'b0}}};
  localparam logic [3:0]           GMAX = 4'd7;

  logic [3:0] gap_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      gap_q <= '0;
    else if (valid_i) gap_q <= strobe ? 4'd0 : gap_q + 4'd1;
  end

  // R3
  vld_follows_input_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_valid_o |-> $past(valid_i));
  // R3
  hold_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sym_valid_o |-> ($stable(sym_re_o) && $stable(sym_im_o)));
  // R10
  idle_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(eta) && $stable(integ) && $stable(adj)));
  // R8
  integ_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (integ <= LIM) && (integ >= -LIM));
  // R8
  adj_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adj <= LIM + LIM) && (adj >= -(LIM + LIM)));
  // R9
  eta_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eta >= 0) && (eta < ONE));
  // R2
  strobe_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gap_q <= GMAX);
endmodule

bind stl_timing_loop stl_checker #(.DW(DW), .CW(CW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .sym_valid_o(sym_valid_o),
  .sym_re_o(sym_re_o), .sym_im_o(sym_im_o), .strobe(strobe), .adj(adj),
  .integ(integ), .eta(eta)
);

// File: tb/sim_stl_timing_loop.sv
`timescale 1ns/1ps
module sim_stl_timing_loop;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic valid = 1'b0;
  logic signed [15:0] din_re = '0, din_im = '0;
  logic sym_valid;
  logic signed [15:0] sym_re, sym_im;

  int checks = 0;
  int failures = 0;
  int xr [0:31];
  int xi [0:31];
  bit ev [0:31];
  int er [0:31];
  int ei [0:31];

  always #5 clk = ~clk;

  stl_timing_loop u0 (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid), .din_re_i(din_re), .din_im_i(din_im),
    .sym_valid_o(sym_valid), .sym_re_o(sym_re), .sym_im_o(sym_im)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // R5 formula, F = 16
  function automatic int farrow_ref(input longint x0, input longint x1, input longint x2,
                                    input longint x3, input longint mu);
    longint v2, v1, t, u, y;
    v2 = (x0 - x1 - x2 + x3) >>> 1;
    v1 = (3*x1 - x0 - x2 - x3) >>> 1;
    t  = (v2 * mu) >>> 16;
    u  = ((t + v1) * mu) >>> 16;
    y  = u + x2;
    if (y > 32767) y = 32767;
    if (y < -32768) y = -32768;
    return int'(y);
  endfunction

  task automatic clear_arrays;
    for (int k = 0; k < 32; k++) begin
      xr[k] = 0; xi[k] = 0; ev[k] = 0; er[k] = 0; ei[k] = 0;
    end
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_ni = 1'b0;
    valid  = 1'b0;
    repeat (2) @(negedge clk);
    chk(sym_valid == 1'b0, "R1 valid in reset", int'(sym_valid), 0);
    chk(sym_re == 0 && sym_im == 0, "R1 symbol in reset", int'(sym_re), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(sym_valid == 1'b0, "R1 valid after reset", int'(sym_valid), 0);
  endtask

  task automatic run_seq(input int n, input int gap, input string tv, input string tval);
    int hr, hi;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      valid  = 1'b1;
      din_re = 16'(xr[k]);
      din_im = 16'(xi[k]);
      @(posedge clk);
      #1;
      chk(sym_valid == ev[k], $sformatf("%s strobe at sample %0d", tv, k), int'(sym_valid), int'(ev[k]));
      if (ev[k]) begin
        chk(int'(sym_re) == er[k], $sformatf("%s re at sample %0d", tval, k), int'(sym_re), er[k]);
        chk(int'(sym_im) == ei[k], $sformatf("%s im at sample %0d", tval, k), int'(sym_im), ei[k]);
      end
      hr = int'(sym_re);
      hi = int'(sym_im);
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        valid  = 1'b0;
        din_re = 16'sh7fff;
        din_im = -16'sh7fff;
        @(posedge clk);
        #1;
        chk(sym_valid == 1'b0, "R10 no symbol on idle", int'(sym_valid), 0);
        chk(int'(sym_re) == hr && int'(sym_im) == hi, "R3 hold on idle", int'(sym_re), hr);
      end
    end
    @(negedge clk);
    valid = 1'b0;
  endtask

  // zero-error pattern: midpoints 0, symbols +-8000
  task automatic fill_nominal(input int n);
    clear_arrays();
    for (int k = 0; k < n; k++) begin
      if (k % 4 == 0)      xr[k] = 0;
      else if (k % 4 == 2) xr[k] = ((k / 4) % 2 == 0) ? 8000 : -8000;
      else                 xr[k] = 3000;
      xi[k] = -xr[k];
    end
    for (int k = 0; k < n; k++) begin
      ev[k] = (k % 4 == 0);
      er[k] = (k >= 2) ? xr[k-2] : 0;
      ei[k] = (k >= 2) ? xi[k-2] : 0;
    end
  endtask

  task automatic t_nominal;
    do_reset();
    fill_nominal(24);
    run_seq(24, 0, "R2", "R4");
  endtask

  task automatic t_gaps;
    do_reset();
    fill_nominal(16);
    run_seq(16, 2, "R10", "R10");
  endtask

  // constant input: error at strobe 4 shifts strobes to 7,11,15,19; value stays c
  task automatic t_const;
    do_reset();
    clear_arrays();
    for (int k = 0; k < 20; k++) begin xr[k] = 12345; xi[k] = -6789; end
    ev[0] = 1; ev[4] = 1; ev[7] = 1; ev[11] = 1; ev[15] = 1; ev[19] = 1;
    for (int k = 4; k < 20; k++) begin er[k] = 12345; ei[k] = -6789; end
    run_seq(20, 0, "R7", "R5");
  endtask

  // error 2^26 at strobe 4: next strobe after 3 samples with mu 61312, then at 11 with mu 61056
  task automatic t_pos_err;
    do_reset();
    clear_arrays();
    xr[0] = 4096; xr[2] = 8192; xr[7] = 8192;
    for (int k = 0; k < 12; k++) xi[k] = xr[k];
    ev[0] = 1; ev[4] = 1; ev[7] = 1; ev[11] = 1;
    er[4] = 8192; ei[4] = 8192;
    er[7] = farrow_ref(xr[7], xr[6], xr[5], xr[4], 61312);
    ei[7] = er[7];
    er[11] = farrow_ref(xr[11], xr[10], xr[9], xr[8], 61056);
    ei[11] = er[11];
    run_seq(12, 0, "R6 R7", "R5 R9");
  endtask

  // error near -4.1e9 at strobe 8: clamped terms keep next interval at 4
  task automatic t_clamp;
    do_reset();
    clear_arrays();
    xr[2] = 32000; xr[4] = 32000; xr[6] = -32000;
    for (int k = 0; k < 13; k++) xi[k] = xr[k];
    ev[0] = 1; ev[4] = 1; ev[8] = 1; ev[12] = 1;
    er[4] = 32000; ei[4] = 32000;
    er[8] = -32000; ei[8] = -32000;
    er[12] = farrow_ref(xr[12], xr[11], xr[10], xr[9], 28108);
    ei[12] = er[12];
    run_seq(13, 0, "R8", "R8");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_nominal();
    t_gaps();
    t_const();
    t_pos_err();
    t_clamp();
    t_nominal();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule